// File: doc/BRIEF.md
# LCD Sync and Pixel-Window Generator

This block produces the line sync, frame sync and active-data window for a 320x240 TFT panel that receives its pixels one byte at a time over an 8-bit parallel port. Every timing figure is counted in port-clock ticks, and a pixel occupies several of them. A format input picks between 16-bit pixels (two bytes) and 24-bit pixels (three bytes). Each format also adds its own packing-pipeline delay before the first valid byte of a line.

A synchronous enable starts the timing. The frame sync is driven low first and the first line sync follows one clock later. While the generator runs, it reports the raw line number, the column of the pixel whose byte is on the port, and which byte of that pixel it is. It raises a byte request one clock before each data-enable clock, so a byte source with one register of latency always has the byte ready in time. Dropping the enable returns the block to idle in one clock.

Top module: `lcdt_sync_gen`

## Requirements
- R1: After reset, and while idle, hs_n and vs_n are 1, de and byte_req are 0, and line_cnt, pix_x and byte_ph are 0.
- R2: With the format bit fmt24=0 a pixel is 2 clocks; with fmt24=1 it is 3 clocks (call this C). hs_n falls at the start of every line, stays low for 2*C clocks, and repeats every 336*C clocks.
- R3: line_cnt is 0 on the first line after start, increments on each hs_n falling edge, and wraps from 243 back to 0. A frame has 2 blank lines, then 240 active lines, then 2 blank lines.
- R4: vs_n goes low one clock before the hs_n fall of line 0 and stays low for 2*C clocks. It repeats every 244 line periods.
- R5: de is 1 only on lines 2 to 241. On those lines it rises 7*C+D clocks after the hs_n fall, where D is 3 for fmt24=0 and 5 for fmt24=1. It then stays high for exactly 320*C clocks.
- R6: While de is 1, pix_x is the pixel column counted from 0 and byte_ph is the byte index within that pixel (0 to C-1). Both are 0 when de is 0.
- R7: byte_req is 1 exactly in the clock before each clock in which de is 1.
- R8: On the first rising clock edge with en=1 from idle, vs_n goes low while hs_n stays high. hs_n goes low on the next edge.
- R9: A clock edge that samples en=0 returns the block to the idle state of R1 at once, from any phase.
- R10: fmt24 is captured on the edge that starts the timing. Changes to it while en stays 1 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable |
| fmt24 | input | 1 | Pixel format: 0 = 16-bit, 1 = 24-bit |
| hs_n | output | 1 | Line sync, active low |
| vs_n | output | 1 | Frame sync, active low |
| de | output | 1 | Active byte window |
| byte_req | output | 1 | Request for the byte needed on the next clock |
| line_cnt | output | 8 | Raw line number within the frame |
| pix_x | output | 9 | Column of the current active pixel |
| byte_ph | output | 2 | Byte index within the current pixel |

## Verification
The syncs, de, line_cnt, pix_x and byte_ph all come from state registers, so they reflect the enable and format sampled one rising edge earlier. byte_req is the exception: it is decoded from the next state and depends on the inputs driven in the current cycle. The reference model in the bench advances its state on each rising edge, using the inputs held since the previous falling edge. It then predicts every output for the current state, and predicts byte_req from the state it will reach at the coming edge. The bench drives new inputs at the falling edge and compares one time unit later, so each comparison sees the cycle in which that result is due.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_LEAD = 2'd1,
    LS_RUN  = 2'd2
  } lcdt_state_e;

  function automatic int unsigned clk_per_pix(input logic wide);
    return wide ? 32'd3 : 32'd2;
  endfunction

endpackage

// File: rtl/lcdt_timing.sv
module lcdt_timing #(
  parameter int unsigned H_TOTAL_PIX = 336,
  parameter int unsigned HS_PIX      = 2,
  parameter int unsigned VS_PIX      = 2,
  parameter int unsigned START_PIX   = 7,
  parameter int unsigned H_ACT_PIX   = 320,
  parameter int unsigned DLY16       = 3,
  parameter int unsigned DLY24       = 5,
  parameter int unsigned HW          = 10
) (
  input  logic          wide,
  output logic [HW-1:0] h_last,
  output logic [HW-1:0] hs_w,
  output logic [HW-1:0] vs_w,
  output logic [HW-1:0] de_beg,
  output logic [HW-1:0] de_end,
  output logic [1:0]    cpp_m1
);
  import lcdt_pkg::*;

  logic [HW-1:0] tab_last [2];
  logic [HW-1:0] tab_hs   [2];
  logic [HW-1:0] tab_vs   [2];
  logic [HW-1:0] tab_beg  [2];
  logic [HW-1:0] tab_end  [2];
  logic [1:0]    tab_cpp  [2];

  for (genvar g = 0; g < 2; g++) begin : g_fmt
    localparam int unsigned CPP = clk_per_pix(g[0]);
    localparam int unsigned DLY = (g == 0) ? DLY16 : DLY24;
    localparam int unsigned BEG = START_PIX * CPP + DLY;
    assign tab_last[g] = HW'(H_TOTAL_PIX * CPP - 1);
    assign tab_hs[g]   = HW'(HS_PIX * CPP);
    assign tab_vs[g]   = HW'(VS_PIX * CPP);
    assign tab_beg[g]  = HW'(BEG);
    assign tab_end[g]  = HW'(BEG + H_ACT_PIX * CPP);
    assign tab_cpp[g]  = 2'(CPP - 1);
  end

  always_comb begin
    h_last = tab_last[wide];
    hs_w   = tab_hs[wide];
    vs_w   = tab_vs[wide];
    de_beg = tab_beg[wide];
    de_end = tab_end[wide];
    cpp_m1 = tab_cpp[wide];
  end

endmodule

// File: rtl/lcdt_counter.sv
module lcdt_counter #(
  parameter int unsigned V_TOT = 244,
  parameter int unsigned HW    = 10,
  parameter int unsigned LW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  fmt24,
  input  logic [HW-1:0]         h_last,
  output lcdt_pkg::lcdt_state_e st_q,
  output lcdt_pkg::lcdt_state_e st_n,
  output logic [HW-1:0]         hcnt_q,
  output logic [HW-1:0]         hcnt_n,
  output logic [LW-1:0]         line_q,
  output logic [LW-1:0]         line_n,
  output logic                  wide_q
);
  import lcdt_pkg::*;

  localparam logic [LW-1:0] LINE_LAST = LW'(V_TOT - 1);

  logic wide_n;
  logic wide_ce;

  always_comb begin
    st_n    = st_q;
    hcnt_n  = hcnt_q;
    line_n  = line_q;
    wide_ce = 1'b0;
    wide_n  = fmt24;
    if (!en) begin
      st_n   = LS_IDLE;
      hcnt_n = '0;
      line_n = '0;
    end else begin
      unique case (st_q)
        LS_IDLE: begin
          st_n    = LS_LEAD;
          wide_ce = 1'b1;
        end
        LS_LEAD: begin
          st_n   = LS_RUN;
          hcnt_n = '0;
          line_n = '0;
        end
        default: begin
          if (hcnt_q == h_last) begin
            hcnt_n = '0;
            line_n = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
          end else begin
            hcnt_n = hcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_IDLE;
      hcnt_q <= '0;
      line_q <= '0;
    end else begin
      st_q   <= st_n;
      hcnt_q <= hcnt_n;
      line_q <= line_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
    end else if (wide_ce) begin
      wide_q <= wide_n;
    end
  end

endmodule

// File: rtl/lcdt_decode.sv
module lcdt_decode #(
  parameter int unsigned V_TOP = 2,
  parameter int unsigned V_ACT = 240,
  parameter int unsigned V_TOT = 244,
  parameter int unsigned HW    = 10,
  parameter int unsigned LW    = 8
) (
  input  lcdt_pkg::lcdt_state_e st,
  input  logic [HW-1:0]         hcnt,
  input  logic [LW-1:0]         line,
  input  logic [HW-1:0]         h_last,
  input  logic [HW-1:0]         hs_w,
  input  logic [HW-1:0]         vs_w,
  input  logic [HW-1:0]         de_beg,
  input  logic [HW-1:0]         de_end,
  output logic                  hs_n,
  output logic                  vs_n,
  output logic                  de
);
  import lcdt_pkg::*;

  localparam logic [LW-1:0] ACT_FIRST = LW'(V_TOP);
  localparam logic [LW-1:0] ACT_STOP  = LW'(V_TOP + V_ACT);
  localparam logic [LW-1:0] LINE_LAST = LW'(V_TOT - 1);

  logic run;
  logic act_line;
  logic vs_head;
  logic vs_tail;

  always_comb begin
    run      = (st == LS_RUN);
    act_line = (line >= ACT_FIRST) && (line < ACT_STOP);
    vs_head  = (line == '0) && (hcnt < (vs_w - 1'b1));
    vs_tail  = (line == LINE_LAST) && (hcnt == h_last);
    hs_n     = !(run && (hcnt < hs_w));
    vs_n     = !((st == LS_LEAD) || (run && (vs_head || vs_tail)));
    de       = run && act_line && (hcnt >= de_beg) && (hcnt < de_end);
  end

endmodule

// File: rtl/lcdt_sync_gen.sv
module lcdt_sync_gen #(
  parameter int unsigned H_TOTAL_PIX = 336,
  parameter int unsigned HS_PIX      = 2,
  parameter int unsigned VS_PIX      = 2,
  parameter int unsigned START_PIX   = 7,
  parameter int unsigned H_ACT_PIX   = 320,
  parameter int unsigned DLY16       = 3,
  parameter int unsigned DLY24       = 5,
  parameter int unsigned V_TOP       = 2,
  parameter int unsigned V_ACT       = 240,
  parameter int unsigned V_BOT       = 2,
  localparam int unsigned V_TOT      = V_TOP + V_ACT + V_BOT,
  localparam int unsigned HW         = $clog2(H_TOTAL_PIX * 3 + 1),
  localparam int unsigned LW         = $clog2(V_TOT),
  localparam int unsigned XW         = $clog2(H_ACT_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fmt24,
  output logic          hs_n,
  output logic          vs_n,
  output logic          de,
  output logic          byte_req,
  output logic [LW-1:0] line_cnt,
  output logic [XW-1:0] pix_x,
  output logic [1:0]    byte_ph
);
  import lcdt_pkg::*;

  lcdt_state_e   st_q, st_n;
  logic [HW-1:0] hcnt_q, hcnt_n;
  logic [LW-1:0] line_q, line_n;
  logic          wide_q;
  logic [HW-1:0] h_last, hs_w, vs_w, de_beg, de_end;
  logic [1:0]    cpp_m1;
  logic          hs_cur, vs_cur, de_cur;
  logic          hs_nxt, vs_nxt, de_nxt;
  logic [XW-1:0] col_q, col_n;
  logic [1:0]    ph_q, ph_n;

  lcdt_timing #(
    .H_TOTAL_PIX(H_TOTAL_PIX), .HS_PIX(HS_PIX), .VS_PIX(VS_PIX),
    .START_PIX(START_PIX), .H_ACT_PIX(H_ACT_PIX),
    .DLY16(DLY16), .DLY24(DLY24), .HW(HW)
  ) u_timing (
    .wide(wide_q), .h_last(h_last), .hs_w(hs_w), .vs_w(vs_w),
    .de_beg(de_beg), .de_end(de_end), .cpp_m1(cpp_m1)
  );

  lcdt_counter #(.V_TOT(V_TOT), .HW(HW), .LW(LW)) u_count (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt24(fmt24), .h_last(h_last),
    .st_q(st_q), .st_n(st_n), .hcnt_q(hcnt_q), .hcnt_n(hcnt_n),
    .line_q(line_q), .line_n(line_n), .wide_q(wide_q)
  );

  lcdt_decode #(.V_TOP(V_TOP), .V_ACT(V_ACT), .V_TOT(V_TOT), .HW(HW), .LW(LW)) u_dec_cur (
    .st(st_q), .hcnt(hcnt_q), .line(line_q), .h_last(h_last), .hs_w(hs_w),
    .vs_w(vs_w), .de_beg(de_beg), .de_end(de_end),
    .hs_n(hs_cur), .vs_n(vs_cur), .de(de_cur)
  );

  lcdt_decode #(.V_TOP(V_TOP), .V_ACT(V_ACT), .V_TOT(V_TOT), .HW(HW), .LW(LW)) u_dec_nxt (
    .st(st_n), .hcnt(hcnt_n), .line(line_n), .h_last(h_last), .hs_w(hs_w),
    .vs_w(vs_w), .de_beg(de_beg), .de_end(de_end),
    .hs_n(hs_nxt), .vs_n(vs_nxt), .de(de_nxt)
  );

  always_comb begin
    col_n = '0;
    ph_n  = '0;
    if (de_nxt && de_cur) begin
      if (ph_q == cpp_m1) begin
        col_n = col_q + 1'b1;
      end else begin
        col_n = col_q;
        ph_n  = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      ph_q  <= '0;
    end else begin
      col_q <= col_n;
      ph_q  <= ph_n;
    end
  end

  assign hs_n     = hs_cur;
  assign vs_n     = vs_cur;
  assign de       = de_cur;
  assign byte_req = de_nxt;
  assign line_cnt = line_q;
  assign pix_x    = col_q;
  assign byte_ph  = ph_q;

  // R9
  idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hs_n && vs_n && !de && !byte_req || en));

  // R7
  req_leads_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> de);

  // R5
  de_outside_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> hs_n);

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_n) && line_cnt != '0) |-> line_cnt == $past(line_cnt) + 1'b1);

  // R6
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && byte_ph == 2'd0) |-> pix_x == $past(pix_x) + 1'b1);

  // R4
  vs_leads_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_n) && line_cnt == '0) |-> (!vs_n && !$past(vs_n)));

  // R8
  lead_before_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vs_n) && $past(st_q) == LS_IDLE) |-> hs_n);

endmodule

// File: tb/tb_lcdt_sync_gen.sv
`timescale 1ns/1ps
module tb_lcdt_sync_gen;

  localparam int HTP = 14, HSP = 2, VSP = 2, STP = 2, HAP = 8;
  localparam int VT = 1, VA = 4, VB = 1, VTOT = VT + VA + VB;
  localparam int LW = $clog2(VTOT);
  localparam int XW = $clog2(HAP);

  logic clk = 1'b0;
  logic rst_n, en, fmt24;
  logic hs_n, vs_n, de, byte_req;
  logic [LW-1:0] line_cnt;
  logic [XW-1:0] pix_x;
  logic [1:0] byte_ph;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string tag = "R1";

  // reference model state: 0 idle, 1 lead, 2 run
  int m_st = 0, m_h = 0, m_l = 0, m_f = 0;

  always #10 clk = ~clk;

  lcdt_sync_gen #(
    .H_TOTAL_PIX(HTP), .HS_PIX(HSP), .VS_PIX(VSP), .START_PIX(STP),
    .H_ACT_PIX(HAP), .DLY16(3), .DLY24(5), .V_TOP(VT), .V_ACT(VA), .V_BOT(VB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt24(fmt24), .hs_n(hs_n), .vs_n(vs_n),
    .de(de), .byte_req(byte_req), .line_cnt(line_cnt), .pix_x(pix_x), .byte_ph(byte_ph)
  );

  function automatic int cpp(int f); return f ? 3 : 2; endfunction
  function automatic int beg(int f); return STP * cpp(f) + (f ? 5 : 3); endfunction

  function automatic int e_de(int s, int h, int l, int f);
    return (s == 2 && l >= VT && l < VT + VA && h >= beg(f) && h < beg(f) + HAP * cpp(f)) ? 1 : 0;
  endfunction

  task automatic chk(string rq, int act, int exp, string nm);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s/%s %s actual=%0d expected=%0d cycle=%0d", rq, tag, nm, act, exp, cyc);
    end
  endtask

  task automatic compare();
    int c, hs, vs, d, px, ph, ns, nh, nl, nf;
    c  = cpp(m_f);
    hs = (m_st == 2 && m_h < HSP * c) ? 0 : 1;
    vs = (m_st == 1 || (m_st == 2 && ((m_l == 0 && m_h < VSP * c - 1) ||
          (m_l == VTOT - 1 && m_h == HTP * c - 1)))) ? 0 : 1;
    d  = e_de(m_st, m_h, m_l, m_f);
    px = d ? (m_h - beg(m_f)) / c : 0;
    ph = d ? (m_h - beg(m_f)) % c : 0;
    ns = m_st; nh = m_h; nl = m_l; nf = m_f;
    next_of(ns, nh, nl, nf);
    chk("R2", int'(hs_n), hs, "hs_n");
    chk("R4", int'(vs_n), vs, "vs_n");
    chk("R5", int'(de), d, "de");
    chk("R3", int'(line_cnt), m_l, "line_cnt");
    chk("R6", int'(pix_x), px, "pix_x");
    chk("R6", int'(byte_ph), ph, "byte_ph");
    chk("R7", int'(byte_req), e_de(ns, nh, nl, nf), "byte_req");
  endtask

  task automatic next_of(inout int s, inout int h, inout int l, inout int f);
    if (!rst_n || !en) begin
      s = 0; h = 0; l = 0;
    end else if (s == 0) begin
      s = 1; f = int'(fmt24);
    end else if (s == 1) begin
      s = 2; h = 0; l = 0;
    end else if (h == HTP * cpp(f) - 1) begin
      h = 0; l = (l == VTOT - 1) ? 0 : l + 1;
    end else begin
      h = h + 1;
    end
  endtask

  task automatic run(int n, logic e, logic f, string t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = e; fmt24 = f; tag = t;
      #1 compare();
      @(posedge clk);
      next_of(m_st, m_h, m_l, m_f);
      cyc++;
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; fmt24 = 1'b0;
    run(4, 1'b0, 1'b0, "R1");
    @(negedge clk) rst_n = 1'b1;
    run(3, 1'b0, 1'b0, "R1");
    run(3, 1'b1, 1'b0, "R8");
    run(360, 1'b1, 1'b0, "R2");
    run(200, 1'b1, 1'b1, "R10");
    run(5, 1'b0, 1'b1, "R9");
    run(3, 1'b1, 1'b1, "R8");
    run(540, 1'b1, 1'b1, "R5");
    run(1, 1'b1, 1'b0, "R8");
    run(4, 1'b0, 1'b0, "R9");
    run(44, 1'b1, 1'b0, "R6");
    run(4, 1'b0, 1'b0, "R9");
    run(20, 1'b1, 1'b0, "R3");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule